// File: doc/BRIEF.md
# Multi-Region Memory Wait-State Controller

This block sits on the CPU side of a single-port memory bus. It maps every request address onto one of four on-chip memory regions and holds back the ready response for a programmable number of cycles. Each region has its own wait count for reads and a separate wait count for writes. The memory arrays are not part of the block, so the ready and error handshake is the whole response it gives.

The wait counts live in a configuration register. That register can only be written after an unlock key has been written to a separate protect register. One configuration write carries a region-select mask, so it can reprogram several regions at the same time. An address that falls outside every region gets an immediate error response.

The requester raises `reqValid` with a stable address and direction, and keeps them stable until `reqReady` is high at a clock edge. In the cycle after that edge, a new request may follow at once.

Top module: `mem_wait_ctrl`

## Requirements
- R1: Region decode and mask bit positions. Region 0 is 0x20000000 to 0x20057FFF, region 1 is 0x20058000 to 0x2005FFFF, region 2 is 0x1FFE0000 to 0x1FFFFFFF and region 3 is 0x200F0000 to 0x200F0FFF. Both ends of each range are inclusive. Region k is selected by bit k of the configuration mask.
- R2: After reset the configuration is locked and every wait count is 0, so any access to a mapped address completes in the cycle it is requested, with `reqErr` low.
- R3: A read with a read wait count of N (0 to 7) is accepted in the first cycle in which `reqValid` is seen while the block is idle. `reqReady` is high exactly N cycles after that cycle, or in the same cycle when N is 0.
- R4: A write follows the same timing as a read, but uses the region's write wait count, which is independent of its read wait count.
- R5: A configuration write (`cfgWe` high, `cfgSel` = 1) made while unlocked loads bits 6:4 of `cfgWdata` as the read wait count and bits 10:8 as the write wait count. It does this for every region whose mask bit (bits 3:0) is set. Regions whose mask bit is clear keep their counts.
- R6: A protect write (`cfgWe` high, `cfgSel` = 0) with `cfgWdata` equal to 0x00000077 unlocks the configuration register.
- R7: A protect write with `cfgWdata` equal to 0x00000076 locks the configuration register.
- R8: A protect write with any other value leaves the lock state unchanged, whether the register is currently locked or unlocked.
- R9: A configuration write made while locked is ignored, and every wait count keeps its value.
- R10: A request to an address outside all four regions completes in the request cycle with `reqErr` high. `reqErr` is low on every completion to a mapped address.
- R11: After `reqReady`, the block is idle again in the next cycle. If `reqValid` is held high, a new request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Access byte address |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 1 | 0 = protect register, 1 = wait configuration register |
| cfgWdata | input | 32 | Register write data |
| reqReady | output | 1 | Access completes at this edge |
| reqErr | output | 1 | Completion is an unmapped-address error |

## Verification
The hardest state to reach is a wait count that is already programmed and is then targeted by a write that must be ignored. Wait counts cannot be read back, so they can only be seen through access latency. The stimulus therefore first unlocks the register and programs distinct non-zero counts. It then relocks the register, or sends stray protect values, and retries configuration writes. Access latencies in every region, for both directions, then show whether anything changed.

Holding `reqValid` high across two back-to-back accesses that have different wait counts shows that the counter reloads cleanly in the cycle after a completion.

// File: rtl/mem_wait_ctrl_pkg.sv
package mem_wait_ctrl_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int WAIT_W      = 3;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 32'h0000_0077;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 32'h0000_0076;

  localparam int MASK_LSB = 0;
  localparam int RD_LSB   = 4;
  localparam int WR_LSB   = 8;

  typedef struct packed {
    logic load;
    logic dec;
  } ctrl_strobe_t;

  function automatic logic [ADDR_W-1:0] regionFirst(input int idx);
    case (idx)
      0:       return 32'h2000_0000;
      1:       return 32'h2005_8000;
      2:       return 32'h1FFE_0000;
      default: return 32'h200F_0000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] regionLast(input int idx);
    case (idx)
      0:       return 32'h2005_7FFF;
      1:       return 32'h2005_FFFF;
      2:       return 32'h1FFF_FFFF;
      default: return 32'h200F_0FFF;
    endcase
  endfunction
endpackage

// File: rtl/mem_wait_region_decode.sv
module mem_wait_region_decode
  import mem_wait_ctrl_pkg::*;
#(
  parameter int REGIONS = NUM_REGIONS,
  parameter int AW      = ADDR_W
) (
  input  logic [AW-1:0]      addr,
  output logic [REGIONS-1:0] hitVec,
  output logic               anyHit
);
  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    localparam logic [AW-1:0] FIRST = regionFirst(r);
    localparam logic [AW-1:0] LAST  = regionLast(r);
    assign hitVec[r] = (addr >= FIRST) && (addr <= LAST);
  end

  assign anyHit = |hitVec;

  // R1: regions never overlap
  always_comb begin
    assert_decode_onehot_R1: assert ($onehot0(hitVec));
  end
endmodule

// File: rtl/mem_wait_datapath.sv
module mem_wait_datapath
  import mem_wait_ctrl_pkg::*;
#(
  parameter int REGIONS = NUM_REGIONS,
  parameter int WW      = WAIT_W,
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic         cfgWe,
  input  logic         cfgSel,
  input  logic [DW-1:0] cfgWdata,
  input  ctrl_strobe_t ctrlStb,
  output logic         reqHit,
  output logic         waitZero,
  output logic         cntLast
);
  logic [REGIONS-1:0]         hitVec;
  logic [REGIONS-1:0][WW-1:0] rdWaitQ;
  logic [REGIONS-1:0][WW-1:0] wrWaitQ;
  logic                       lockedQ;
  logic [WW-1:0]              waitSel;
  logic [WW-1:0]              cntQ;
  logic                       keyWr;
  logic                       tableWr;

  mem_wait_region_decode #(.REGIONS(REGIONS), .AW(AW)) u_decode (
    .addr   (reqAddr),
    .hitVec (hitVec),
    .anyHit (reqHit)
  );

  assign keyWr   = cfgWe && !cfgSel;
  assign tableWr = cfgWe && cfgSel && !lockedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= 1'b1;
    end else if (keyWr) begin
      if (cfgWdata == KEY_OPEN)       lockedQ <= 1'b0;
      else if (cfgWdata == KEY_CLOSE) lockedQ <= 1'b1;
    end
  end

  for (genvar r = 0; r < REGIONS; r++) begin : g_table
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdWaitQ[r] <= '0;
        wrWaitQ[r] <= '0;
      end else if (tableWr && cfgWdata[MASK_LSB + r]) begin
        rdWaitQ[r] <= cfgWdata[RD_LSB +: WW];
        wrWaitQ[r] <= cfgWdata[WR_LSB +: WW];
      end
    end
  end

  always_comb begin
    waitSel = '0;
    for (int r = 0; r < REGIONS; r++) begin
      if (hitVec[r]) waitSel = waitSel | (reqWrite ? wrWaitQ[r] : rdWaitQ[r]);
    end
  end

  assign waitZero = (waitSel == '0);

  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (ctrlStb.load) cntQ <= waitSel;
    else if (ctrlStb.dec)  cntQ <= cntQ - 1'b1;
  end

  assign cntLast = (cntQ == {{(WW-1){1'b0}}, 1'b1});

  // R9: a locked table does not move on a configuration write
  assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && cfgWe && cfgSel) |=> ($stable(rdWaitQ) && $stable(wrWaitQ)));
  // R6: open key unlocks
  assert_open_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && cfgWdata == KEY_OPEN) |=> !lockedQ);
  // R7: close key locks
  assert_close_key_R7: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && cfgWdata == KEY_CLOSE) |=> lockedQ);
  // R8: any other protect value keeps the lock state
  assert_other_key_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && cfgWdata != KEY_OPEN && cfgWdata != KEY_CLOSE) |=> $stable(lockedQ));
  // R3: the controller only loads a non-zero wait into the counter
  assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.load |=> (cntQ != '0));
endmodule

// File: rtl/mem_wait_control.sv
module mem_wait_control
  import mem_wait_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqHit,
  input  logic         waitZero,
  input  logic         cntLast,
  output ctrl_strobe_t ctrlStb,
  output logic         reqReady,
  output logic         reqErr
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    ctrlStb     = '0;
    reqReady    = 1'b0;
    reqErr      = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqHit) begin
            reqReady = 1'b1;
            reqErr   = 1'b1;
          end else if (waitZero) begin
            reqReady = 1'b1;
          end else begin
            ctrlStb.load = 1'b1;
            stateD       = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cntLast) begin
          reqReady = 1'b1;
          stateD   = ST_IDLE;
        end else begin
          ctrlStb.dec = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R11: completion from the wait state returns to idle
  assert_back_to_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && reqReady) |=> (stateQ == ST_IDLE));
  // R10: an error never comes while waiting out a count
  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (stateQ == ST_IDLE && reqReady));
  // R3: a waiting cycle never also counts down on completion
  assert_no_dec_on_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !ctrlStb.dec && !ctrlStb.load);
endmodule

// File: rtl/mem_wait_ctrl.sv
module mem_wait_ctrl
  import mem_wait_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic              reqReady,
  output logic              reqErr
);
  ctrl_strobe_t ctrlStb;
  logic         reqHit;
  logic         waitZero;
  logic         cntLast;

  mem_wait_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .ctrlStb  (ctrlStb),
    .reqHit   (reqHit),
    .waitZero (waitZero),
    .cntLast  (cntLast)
  );

  mem_wait_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqHit   (reqHit),
    .waitZero (waitZero),
    .cntLast  (cntLast),
    .ctrlStb  (ctrlStb),
    .reqReady (reqReady),
    .reqErr   (reqErr)
  );
endmodule

// File: tb/mem_wait_ctrl_tb.sv
module mem_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic        reqReady;
  logic        reqErr;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 0;
  string curTag = "R2";

  int mRd [4];
  int mWr [4];
  bit mLocked;
  bit mBusy;
  int mLeft;

  mem_wait_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .reqReady(reqReady), .reqErr(reqErr)
  );

  always #4 clk = ~clk;

  function automatic int mapRegion(input logic [31:0] a);
    if (a >= 32'h2000_0000 && a < 32'h2005_8000) return 0;
    if (a >= 32'h2005_8000 && a < 32'h2006_0000) return 1;
    if (a >= 32'h1FFE_0000 && a < 32'h2000_0000) return 2;
    if (a >= 32'h200F_0000 && a < 32'h200F_1000) return 3;
    return -1;
  endfunction

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eRdy, eErr;
      int reg_i;
      eRdy = 0; eErr = 0;
      if (mBusy) begin
        eRdy = (mLeft == 1);
      end else if (reqValid) begin
        reg_i = mapRegion(reqAddr);
        if (reg_i < 0) begin eRdy = 1; eErr = 1; end
        else eRdy = ((reqWrite ? mWr[reg_i] : mRd[reg_i]) == 0);
      end
      checks++;
      if (reqReady !== eRdy || reqErr !== eErr) begin
        fails++;
        $display("FAIL %s: ready=%0b err=%0b expected ready=%0b err=%0b",
                 curTag, reqReady, reqErr, eRdy, eErr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mLocked = 1; mBusy = 0; mLeft = 0;
      for (int i = 0; i < 4; i++) begin mRd[i] = 0; mWr[i] = 0; end
    end else begin
      if (mBusy) begin
        if (mLeft == 1) mBusy = 0; else mLeft--;
      end else if (reqValid && mapRegion(reqAddr) >= 0) begin
        int w;
        w = reqWrite ? mWr[mapRegion(reqAddr)] : mRd[mapRegion(reqAddr)];
        if (w > 0) begin mBusy = 1; mLeft = w; end
      end
      if (cfgWe && !cfgSel) begin
        if (cfgWdata == 32'h77) mLocked = 0;
        else if (cfgWdata == 32'h76) mLocked = 1;
      end else if (cfgWe && cfgSel && !mLocked) begin
        for (int i = 0; i < 4; i++) if (cfgWdata[i]) begin
          mRd[i] = int'(cfgWdata[6:4]);
          mWr[i] = int'(cfgWdata[10:8]);
        end
      end
    end
  end

  task automatic regWrite(input bit sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfgWe = 1; cfgSel = sel; cfgWdata = d;
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic cfgWaits(input logic [3:0] mask, input int rd, input int wr);
    regWrite(1'b1, {21'd0, wr[2:0], 1'b0, rd[2:0], mask});
  endtask

  // one access; latency counted from acceptance, valid dropped after ready
  task automatic access(input logic [31:0] a, input bit wr, input int expLat,
                        input bit expErr, input string tag);
    int lat;
    curTag = tag;
    @(posedge clk); #1;
    reqValid = 1; reqAddr = a; reqWrite = wr;
    lat = 0;
    @(negedge clk);
    while (!reqReady && lat < 20) begin lat++; @(negedge clk); end
    checks++;
    if (lat != expLat || reqErr !== expErr) begin
      fails++;
      $display("FAIL %s: addr=%h wr=%0b latency=%0d err=%0b expected latency=%0d err=%0b",
               tag, a, wr, lat, reqErr, expLat, expErr);
    end
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    checks++;
    if (reqReady !== 0 || reqErr !== 0) begin
      fails++;
      $display("FAIL R2: idle ready=%0b err=%0b expected 0 0", reqReady, reqErr);
    end
    // R2 / R1: zero wait everywhere after reset, both directions
    access(32'h2000_0000, 0, 0, 0, "R2");
    access(32'h2005_7FFF, 1, 0, 0, "R2");
    access(32'h2005_8000, 0, 0, 0, "R2");
    access(32'h1FFE_0000, 1, 0, 0, "R2");
    access(32'h200F_0FFF, 0, 0, 0, "R2");
    // R10: unmapped addresses, including just outside each range
    access(32'h3000_0000, 0, 0, 1, "R10");
    access(32'h1FFD_FFFF, 1, 0, 1, "R10");
    access(32'h2006_0000, 0, 0, 1, "R10");
    access(32'h200F_1000, 1, 0, 1, "R10");
    // R9: locked after reset, table write ignored
    cfgWaits(4'hF, 5, 3);
    access(32'h2000_0100, 0, 0, 0, "R9");
    access(32'h200F_0000, 1, 0, 0, "R9");
    // R8: stray key while locked keeps it locked
    regWrite(1'b0, 32'h0000_0012);
    regWrite(1'b0, 32'h0000_0177);
    cfgWaits(4'hF, 4, 4);
    access(32'h2005_8004, 0, 0, 0, "R8");
    // R6 + R5 + R3 + R4
    regWrite(1'b0, 32'h77);
    cfgWaits(4'h1, 3, 6);
    access(32'h2001_0000, 0, 3, 0, "R3");
    access(32'h2004_0000, 1, 6, 0, "R4");
    access(32'h2005_8000, 0, 0, 0, "R5");
    cfgWaits(4'hC, 7, 1);
    access(32'h1FFF_FFFC, 0, 7, 0, "R5");
    access(32'h200F_0000, 1, 1, 0, "R4");
    access(32'h200F_0800, 0, 7, 0, "R3");
    access(32'h2000_0000, 0, 3, 0, "R5");
    cfgWaits(4'h2, 0, 2);
    access(32'h2005_FFFF, 0, 0, 0, "R3");
    access(32'h2005_A000, 1, 2, 0, "R4");
    access(32'h1FFE_0000, 1, 1, 0, "R5");
    access(32'h2006_0000, 0, 0, 1, "R10");
    // R8: stray key while unlocked keeps it unlocked
    regWrite(1'b0, 32'h0000_0000);
    cfgWaits(4'h8, 2, 5);
    access(32'h200F_0010, 0, 2, 0, "R8");
    access(32'h200F_0010, 1, 5, 0, "R8");
    // R7: relock, then table write ignored
    regWrite(1'b0, 32'h76);
    cfgWaits(4'hF, 1, 1);
    access(32'h2000_0040, 0, 3, 0, "R7");
    access(32'h2005_8000, 1, 2, 0, "R9");
    // R11: valid held across two accesses with different waits
    curTag = "R11";
    @(posedge clk); #1;
    reqValid = 1; reqAddr = 32'h2000_0000; reqWrite = 0;
    begin
      int lat;
      lat = 0;
      @(negedge clk);
      while (!reqReady && lat < 20) begin lat++; @(negedge clk); end
      checks++;
      if (lat != 3) begin
        fails++;
        $display("FAIL R11: first latency=%0d expected 3", lat);
      end
      @(posedge clk); #1;
      reqAddr = 32'h2005_8000; reqWrite = 1;
      lat = 0;
      @(negedge clk);
      while (!reqReady && lat < 20) begin lat++; @(negedge clk); end
      checks++;
      if (lat != 2) begin
        fails++;
        $display("FAIL R11: second latency=%0d expected 2", lat);
      end
      @(posedge clk); #1;
      reqValid = 0;
    end
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule